// File: doc/BRIEF.md
# Embedded Core Test Wrapper

This block sits between a host chip and one embedded core and gives test access to both sides of the core boundary. Each core input and each core output has one wrapper cell. The cells are chained into a single serial wrapper register with one serial input and one serial output. A two-bit mode selects one of three uses: plain functional pass-through, an external test that drives and observes the interconnect around the core, or an internal test that drives and observes the core's own logic.

The two sides swap roles with the mode. In internal test, the input-side cells drive the core inputs and the output-side cells record the core outputs. In external test, the output-side cells drive the host side of the core outputs and the input-side cells record what arrives from the host. Every cell has a shift stage and a separate update stage. Only the update stage drives a controlled terminal, so a vector can be shifted in while the previous vector stays applied.

The mode, the capture, shift and update strobes, and the serial bit are plain level inputs sampled on each rising clock edge. There is no valid/ready handshake and no back-pressure: every strobe that is asserted at an edge acts at that edge. If several strobes are asserted at the same edge, only the one with the highest priority acts.

Top module: `core_test_wrapper`

## Requirements
- R1: While reset is active, and at the first edge after it, every shift stage and every update stage reads 0. `wso` is therefore 0, and in internal test `core_in` reads all zeros.
- R2: With `test_mode` 2'b00, and also with the unused code 2'b11, `core_in` equals `host_in` and `host_out` equals `core_out`. Both paths are combinational.
- R3: With `test_mode` 2'b01 (external test), `host_out[j]` equals the update stage of output cell j, and `core_in` equals `host_in`.
- R4: With `test_mode` 2'b10 (internal test), `core_in[i]` equals the update stage of input cell i, and `host_out` equals `core_out`.
- R5: At an edge with `cap_en` high, input cell i loads `host_in[i]` and output cell j loads `core_out[j]` into its shift stage. This happens in every mode.
- R6: At an edge with `shf_en` high and `cap_en` low, the chain moves one position. The chain order is `wsi` → input cell 0 … input cell NUM_IN-1 → output cell 0 … output cell NUM_OUT-1 → `wso`. `wso` is the shift stage of the last output cell.
- R7: At an edge with `upd_en` high and both `cap_en` and `shf_en` low, every update stage copies its shift stage. At every other edge the update stages hold, so shifting never changes a controlled terminal.
- R8: Priority at an edge is capture, then shift, then update. A lower strobe that is asserted together with a higher one has no effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wrapper clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 2 | 00/11 functional, 01 external test, 10 internal test |
| cap_en | input | 1 | Parallel capture strobe |
| shf_en | input | 1 | Serial shift strobe |
| upd_en | input | 1 | Update strobe |
| wsi | input | 1 | Wrapper serial input |
| wso | output | 1 | Wrapper serial output (last shift stage) |
| host_in | input | NUM_IN | Host-side values headed for the core inputs |
| core_in | output | NUM_IN | Values applied to the core input terminals |
| core_out | input | NUM_OUT | Values from the core output terminals |
| host_out | output | NUM_OUT | Values delivered to the host chip |

## Verification
`core_in` and `host_out` are combinational in the mode and the update stages. The bench therefore checks them in the same cycle as the stimulus: it drives at the falling edge and compares one nanosecond later against a bench model that reflects all edges up to then. Capture, shift and update take effect at the next rising edge. Their effects on `wso` and on the driven terminals are due from that edge on, and are compared at the following falling edge. A random run with a fixed seed, mixing all four mode codes and overlapping strobes, is followed by directed cases: reset, the 2'b11 code, all strobes together, and a full walk of a pattern through the chain.

// File: rtl/wrap_pkg.sv
package wrap_pkg;
  typedef enum logic [1:0] {
    WM_FUNC = 2'b00,
    WM_EXT  = 2'b01,
    WM_INT  = 2'b10,
    WM_SPARE = 2'b11
  } wrap_mode_e;

  typedef struct packed {
    logic cap;
    logic shf;
    logic upd;
  } wrap_op_t;
endpackage

// File: rtl/wrap_ctrl.sv
module wrap_ctrl
  import wrap_pkg::*;
(
  input  logic [1:0] test_mode,
  input  logic       cap_en,
  input  logic       shf_en,
  input  logic       upd_en,
  output wrap_op_t   op,
  output logic       sel_ext,
  output logic       sel_int
);
  wrap_mode_e mode_q;

  always_comb begin
    mode_q  = wrap_mode_e'(test_mode);
    sel_ext = 1'b0;
    sel_int = 1'b0;
    unique case (mode_q)
      WM_EXT:  sel_ext = 1'b1;
      WM_INT:  sel_int = 1'b1;
      default: begin
        sel_ext = 1'b0;
        sel_int = 1'b0;
      end
    endcase
  end

  // capture beats shift, shift beats update
  always_comb begin
    op.cap = cap_en;
    op.shf = shf_en & ~cap_en;
    op.upd = upd_en & ~cap_en & ~shf_en;
  end
endmodule

// File: rtl/wrap_cell.sv
module wrap_cell
  import wrap_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  wrap_op_t op,
  input  logic     cap_d,
  input  logic     ser_d,
  output logic     ser_q,
  output logic     upd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q <= 1'b0;
    end else if (op.cap) begin
      ser_q <= cap_d;
    end else if (op.shf) begin
      ser_q <= ser_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q <= 1'b0;
    end else if (op.upd) begin
      upd_q <= ser_q;
    end
  end
endmodule

// File: rtl/wrap_register.sv
module wrap_register
  import wrap_pkg::*;
#(
  parameter int LEN = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  wrap_op_t       op,
  input  logic [LEN-1:0] cap_vec,
  input  logic           wsi,
  output logic [LEN-1:0] sh_q,
  output logic [LEN-1:0] up_q
);
  logic [LEN-1:0] ser_in;

  generate
    for (genvar k = 0; k < LEN; k++) begin : g_cell
      if (k == 0) begin : g_head
        assign ser_in[k] = wsi;
      end else begin : g_link
        assign ser_in[k] = sh_q[k-1];
      end
      wrap_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .cap_d (cap_vec[k]),
        .ser_d (ser_in[k]),
        .ser_q (sh_q[k]),
        .upd_q (up_q[k])
      );
    end
  endgenerate
endmodule

// File: rtl/wrap_terms.sv
module wrap_terms #(
  parameter int NUM_IN  = 6,
  parameter int NUM_OUT = 5
) (
  input  logic               sel_ext,
  input  logic               sel_int,
  input  logic [NUM_IN-1:0]  host_in,
  input  logic [NUM_IN-1:0]  up_in,
  input  logic [NUM_OUT-1:0] core_out,
  input  logic [NUM_OUT-1:0] up_out,
  output logic [NUM_IN-1:0]  core_in,
  output logic [NUM_OUT-1:0] host_out
);
  generate
    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
      assign core_in[i] = sel_int ? up_in[i] : host_in[i];
    end
    for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
      assign host_out[j] = sel_ext ? up_out[j] : core_out[j];
    end
  endgenerate
endmodule

// File: rtl/core_test_wrapper.sv
module core_test_wrapper
  import wrap_pkg::*;
#(
  parameter int NUM_IN  = 6,
  parameter int NUM_OUT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         test_mode,
  input  logic               cap_en,
  input  logic               shf_en,
  input  logic               upd_en,
  input  logic               wsi,
  output logic               wso,
  input  logic [NUM_IN-1:0]  host_in,
  output logic [NUM_IN-1:0]  core_in,
  input  logic [NUM_OUT-1:0] core_out,
  output logic [NUM_OUT-1:0] host_out
);
  localparam int CHAIN = NUM_IN + NUM_OUT;

  wrap_op_t         op;
  logic             sel_ext;
  logic             sel_int;
  logic [CHAIN-1:0] cap_vec;
  logic [CHAIN-1:0] sh_q;
  logic [CHAIN-1:0] up_q;

  wrap_ctrl u_ctrl (
    .test_mode (test_mode),
    .cap_en    (cap_en),
    .shf_en    (shf_en),
    .upd_en    (upd_en),
    .op        (op),
    .sel_ext   (sel_ext),
    .sel_int   (sel_int)
  );

  // input cells sit at the low end of the chain, output cells above them
  assign cap_vec = {core_out, host_in};

  wrap_register #(.LEN(CHAIN)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .cap_vec (cap_vec),
    .wsi     (wsi),
    .sh_q    (sh_q),
    .up_q    (up_q)
  );

  assign wso = sh_q[CHAIN-1];

  wrap_terms #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_terms (
    .sel_ext  (sel_ext),
    .sel_int  (sel_int),
    .host_in  (host_in),
    .up_in    (up_q[NUM_IN-1:0]),
    .core_out (core_out),
    .up_out   (up_q[CHAIN-1:NUM_IN]),
    .core_in  (core_in),
    .host_out (host_out)
  );
endmodule

// File: rtl/wrap_checker.sv
module wrap_checker #(
  parameter int NUM_IN  = 6,
  parameter int NUM_OUT = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [1:0]                 test_mode,
  input logic                       cap_en,
  input logic                       shf_en,
  input logic                       upd_en,
  input logic                       wsi,
  input logic                       wso,
  input logic [NUM_IN-1:0]          host_in,
  input logic [NUM_IN-1:0]          core_in,
  input logic [NUM_OUT-1:0]         core_out,
  input logic [NUM_OUT-1:0]         host_out,
  input logic [NUM_IN+NUM_OUT-1:0]  sh_q,
  input logic [NUM_IN+NUM_OUT-1:0]  up_q
);
  localparam int CHAIN = NUM_IN + NUM_OUT;

  a_r2_func_in: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode == 2'b00 || test_mode == 2'b11) |-> (core_in == host_in && host_out == core_out));

  a_r3_ext_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode == 2'b01) |-> (host_out == up_q[CHAIN-1:NUM_IN]));

  a_r4_int_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode == 2'b10) |-> (core_in == up_q[NUM_IN-1:0]));

  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (sh_q == {$past(core_out), $past(host_in)}));

  a_r6_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_en && !cap_en) |=> (sh_q == {$past(sh_q[CHAIN-2:0]), $past(wsi)}));

  a_r7_upd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en || shf_en || !upd_en) |=> $stable(up_q));

  a_r8_upd_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !cap_en && !shf_en) |=> (up_q == $past(sh_q)));

  a_r6_wso_tail: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_en && !cap_en) |=> (wso == $past(sh_q[CHAIN-2])));
endmodule

bind core_test_wrapper wrap_checker #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .test_mode (test_mode),
  .cap_en    (cap_en),
  .shf_en    (shf_en),
  .upd_en    (upd_en),
  .wsi       (wsi),
  .wso       (wso),
  .host_in   (host_in),
  .core_in   (core_in),
  .core_out  (core_out),
  .host_out  (host_out),
  .sh_q      (sh_q),
  .up_q      (up_q)
);

// File: tb/core_test_wrapper_tb_top.sv
`timescale 1ns/1ps
module core_test_wrapper_tb_top;
  localparam int NI = 6;
  localparam int NO = 5;
  localparam int CH = NI + NO;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    test_mode = 2'b00;
  logic          cap_en = 1'b0;
  logic          shf_en = 1'b0;
  logic          upd_en = 1'b0;
  logic          wsi = 1'b0;
  logic          wso;
  logic [NI-1:0] host_in = '0;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out = '0;
  logic [NO-1:0] host_out;

  int vectors = 0;
  int miscompares = 0;

  logic [CH-1:0] m_sh = '0;
  logic [CH-1:0] m_up = '0;
  string wso_tag = "R1";

  always #2 clk = ~clk;

  core_test_wrapper #(.NUM_IN(NI), .NUM_OUT(NO)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .cap_en    (cap_en),
    .shf_en    (shf_en),
    .upd_en    (upd_en),
    .wsi       (wsi),
    .wso       (wso),
    .host_in   (host_in),
    .core_in   (core_in),
    .core_out  (core_out),
    .host_out  (host_out)
  );

  function automatic logic [NI-1:0] exp_core_in(input logic [1:0] md,
      input logic [NI-1:0] hi, input logic [CH-1:0] up);
    return (md == 2'b10) ? up[NI-1:0] : hi;
  endfunction

  function automatic logic [NO-1:0] exp_host_out(input logic [1:0] md,
      input logic [NO-1:0] co, input logic [CH-1:0] up);
    return (md == 2'b01) ? up[CH-1:NI] : co;
  endfunction

  function automatic string term_tag(input logic [1:0] md);
    case (md)
      2'b01:   return "R3";
      2'b10:   return "R4,R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // drive at falling edge, check combinational and serial outputs, then model the edge
  task automatic step(input logic [1:0] md, input logic c, input logic s, input logic u,
      input logic w, input logic [NI-1:0] hi, input logic [NO-1:0] co, input string otag);
    @(negedge clk);
    test_mode = md; cap_en = c; shf_en = s; upd_en = u; wsi = w;
    host_in = hi; core_out = co;
    #1;
    check(wso_tag, 32'(wso), 32'(m_sh[CH-1]));
    check(term_tag(md), 32'(core_in), 32'(exp_core_in(md, hi, m_up)));
    check(term_tag(md), 32'(host_out), 32'(exp_host_out(md, co, m_up)));
    @(posedge clk);
    if (c) begin
      m_sh = {co, hi};
      wso_tag = (s || u) ? "R8" : "R5";
    end else if (s) begin
      m_sh = {m_sh[CH-2:0], w};
      wso_tag = u ? "R8" : "R6";
    end else if (u) begin
      m_up = m_sh;
      wso_tag = "R7";
    end
    if (otag != "") wso_tag = otag;
  endtask

  initial begin
    #(200000 * 4);
    miscompares++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [CH-1:0] pat;
    void'($urandom(32'h1c0de));
    // R1: reset state
    #1;
    check("R1", 32'(wso), 32'(0));
    test_mode = 2'b10;
    #1;
    check("R1", 32'(core_in), 32'(0));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 6'h2a, 5'h15, "R1");

    // R2: spare code 11 behaves as functional
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 6'h3c, 5'h0f, "");
    step(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 6'h05, 5'h1a, "");

    // R6: walk a pattern through the whole chain, then R7 apply it
    pat = CH'(11'h5b3);
    for (int k = 0; k < CH; k++)
      step(2'b10, 1'b0, 1'b1, 1'b0, pat[k], 6'h11, 5'h03, "");
    for (int k = 0; k < CH; k++)
      step(2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 6'h22, 5'h04, "");
    for (int k = 0; k < CH; k++)
      step(2'b10, 1'b0, 1'b1, 1'b0, pat[k], 6'h33, 5'h05, "");
    step(2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 6'h00, 5'h00, "");
    step(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 6'h3f, 5'h1f, "");

    // R8: all strobes together, then shift with update
    step(2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 6'h2d, 5'h12, "");
    step(2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 6'h01, 5'h02, "");
    step(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 6'h01, 5'h02, "");

    // R5: capture in every mode, shifted out
    for (int m = 0; m < 4; m++) begin
      step(2'(m), 1'b1, 1'b0, 1'b0, 1'b0, 6'(m * 13 + 7), 5'(m * 5 + 3), "");
      for (int k = 0; k < CH; k++)
        step(2'(m), 1'b0, 1'b1, 1'b0, 1'b0, 6'h0, 5'h0, "");
    end

    // random mix of modes and strobes
    for (int n = 0; n < 3000; n++)
      step(2'($urandom), ($urandom % 5) == 0, ($urandom % 2) == 0, ($urandom % 4) == 0,
           1'($urandom), 6'($urandom), 5'($urandom), "");

    step(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 6'h0, 5'h0, "");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule